// File: doc/BRIEF.md
# Serial Flash Transaction Engine

This block runs one serial flash transaction for each start command it receives over a 32-bit register bus. Software first writes a configuration word. That word sets whether a command byte is sent, how many address, dummy, write and read bytes follow, and how many IO lanes (1, 2 or 4) each phase uses. Software also loads the opcode, the address word and up to sixteen bytes of write data. It then writes the start bit. The engine drives a divided serial clock and one of four active-low chip-selects. It walks through the phases that have a nonzero length, and it leaves up to sixteen received bytes in four read words.

While a transaction is in flight the register file is frozen. Software polls the start bit until the engine clears it. A software chip-select hold keeps the selected device selected between transactions. This lets several short transactions form one continuous flash operation, for example a command and address followed by several data chunks.

Top module: `flash_xact_engine`

## Requirements
- R1: After reset the configuration (0x08), command (0x10), address (0x14), write-data (0x20–0x2C) and read-data (0x30–0x3C) words read 0. The control word (0x0C) reads 0x0001_0000 (hold released, device 0, idle). All cs_n are high, sck is low and io_oe is 0.
- R2: Writing a 1 to control bit 0 while idle starts a transaction. Bit 0 reads 1 until the transaction ends and then reads 0. A transaction with no nonzero phase also ends and clears the bit.
- R3: Phases run in the order command, address, dummy, write data, read data, and a phase of zero length is skipped. Configuration bit 10 enables a one-byte command phase that sends command-register bits 7:0. Byte counts sit in bits 13:11 (address, values above 4 act as 4), 23:21 (dummy), 20:16 (write) and 28:24 (read); write and read counts above 16 act as 16.
- R4: The lane codes sit in configuration bits 1:0 (command), 3:2 (address), 7:6 (dummy), 5:4 (write) and 9:8 (read).
  - Code 0 (and code 3) selects one lane, code 1 selects two lanes and code 2 selects four lanes.
  - Driven bits use io[0], io[1:0] or io[3:0]. The earliest bit of each group goes on the highest lane used.
  - A phase lasts bytes×8/lanes clocks.
- R5: The address phase sends the low N bytes of the address word, most significant of them first, where N is the address count.
- R6: Write byte i comes from write word i/4, bits 8·(i mod 4)+7 down to 8·(i mod 4). Bytes are sent in order 0, 1, 2 and so on, each most significant bit first.
- R7: During dummy clocks io_oe is 0.
- R8: Read data is handled as follows.
  - During read clocks io_oe is 0. The engine samples io at the rising edge of sck: io[1] in single-lane mode, io[1:0] or io[3:0] otherwise.
  - Received byte i is stored in the same byte position as R6, and read bytes at or beyond the read count are 0.
  - Every transaction rewrites all four read words.
- R9: Control bits 9:8 pick the device. During a transaction only that cs_n is low, and at most one cs_n is ever low.
- R10: Control bit 16 is the hold release. While it is 0 the selected cs_n stays low between transactions. While it is 1, cs_n returns high when each transaction ends.
- R11: While a transaction runs, every register write is ignored, including a write that lands in the cycle the transaction ends. A new start write therefore neither restarts the transaction nor changes the device.
- R12: sck idles low. Each sck period is one clk cycle low followed by one clk cycle high. Outputs change only as sck falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 7 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| sck | output | 1 | Serial clock |
| cs_n | output | 4 | Active-low device selects |
| io_out | output | 4 | Serial data out |
| io_oe | output | 4 | Per-lane output enable |
| io_in | input | 4 | Serial data in |

## Verification
The two functions that can meet in one cycle are a register write and the engine's final step, in which it clears the start bit and commits the read words. The bench counts the exact clock edge at which a known-length transaction finishes. It lands a command-register write on that edge and then another on the following edge. The first write must leave the command word unchanged and the second must take effect. A start write issued halfway through a transaction must likewise leave the sck count and the selected cs_n unchanged.

// File: rtl/flash_xact_engine.sv
module flash_xact_engine #(
  parameter int NW = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [6:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        sck,
  output logic [3:0]  cs_n,
  output logic [3:0]  io_out,
  output logic [3:0]  io_oe,
  input  logic [3:0]  io_in
);
  localparam int NB = NW * 4;
  localparam int SW = NB * 8;
  localparam logic [2:0] PH_DONE = 3'd5;

  logic [31:0] cfg, cmd_r, adr_r;
  logic [NW-1:0][31:0] wd, rd, rnext;
  logic busy, rel, half;
  logic [1:0] dev;
  logic [2:0] ph, first, after, ld_ph;
  logic [7:0] cnt;
  logic [SW-1:0] sh, rsh, wstream, ld_val, tmp;
  logic [4:0][7:0] cyc;
  logic [1:0] code_cur, ps_cur;
  logic [3:0] mask;
  logic [31:0] adr_sh;

  function automatic logic [1:0] sh_of(input logic [1:0] c);
    return (c == 2'd3) ? 2'd0 : c;
  endfunction

  function automatic logic [2:0] nxt(input logic [2:0] from, input logic [4:0][7:0] c);
    nxt = PH_DONE;
    for (int i = 4; i >= 0; i--)
      if (3'(i) >= from && c[i] != 8'd0) nxt = 3'(i);
  endfunction

  wire [2:0] ad_n = (cfg[13:11] > 3'd4) ? 3'd4 : cfg[13:11];
  wire [2:0] dm_n = cfg[23:21];
  wire [4:0] wr_n = (cfg[20:16] > 5'd16) ? 5'd16 : cfg[20:16];
  wire [4:0] rd_n = (cfg[28:24] > 5'd16) ? 5'd16 : cfg[28:24];

  always_comb begin
    cyc[0] = cfg[10] ? (8'd8 >> sh_of(cfg[1:0])) : 8'd0;
    cyc[1] = {2'b0, ad_n, 3'b0} >> sh_of(cfg[3:2]);
    cyc[2] = {2'b0, dm_n, 3'b0} >> sh_of(cfg[7:6]);
    cyc[3] = {wr_n, 3'b0} >> sh_of(cfg[5:4]);
    cyc[4] = {rd_n, 3'b0} >> sh_of(cfg[9:8]);
    case (ph)
      3'd0: code_cur = cfg[1:0];
      3'd1: code_cur = cfg[3:2];
      3'd2: code_cur = cfg[7:6];
      3'd3: code_cur = cfg[5:4];
      default: code_cur = cfg[9:8];
    endcase
    ps_cur = sh_of(code_cur);
    mask = (ps_cur == 2'd2) ? 4'hF : (ps_cur == 2'd1) ? 4'h3 : 4'h1;
  end

  assign first = nxt(3'd0, cyc);
  assign after = nxt(ph + 3'd1, cyc);
  assign ld_ph = busy ? after : first;
  assign adr_sh = adr_r << (8 * (4 - int'(ad_n)));

  always_comb begin
    for (int i = 0; i < NB; i++)
      wstream[SW-1-8*i -: 8] = wd[i/4][8*(i%4) +: 8];
    case (ld_ph)
      3'd0: ld_val = {cmd_r[7:0], {(SW-8){1'b0}}};
      3'd1: ld_val = {adr_sh, {(SW-32){1'b0}}};
      3'd3: ld_val = wstream;
      default: ld_val = '0;
    endcase
    rnext = '0;
    tmp = '0;
    for (int i = 0; i < NB; i++)
      if (i < int'(rd_n)) begin
        tmp = rsh >> (8 * (int'(rd_n) - 1 - i));
        rnext[i/4][8*(i%4) +: 8] = tmp[7:0];
      end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0; cmd_r <= '0; adr_r <= '0; wd <= '0; rd <= '0;
      busy <= 1'b0; rel <= 1'b1; dev <= '0; ph <= PH_DONE;
      half <= 1'b0; cnt <= '0; sh <= '0; rsh <= '0; sck <= 1'b0;
    end else if (!busy) begin
      if (bus_we) begin
        if (bus_addr == 7'h08) cfg <= bus_wdata;
        if (bus_addr == 7'h10) cmd_r <= bus_wdata;
        if (bus_addr == 7'h14) adr_r <= bus_wdata;
        if (bus_addr[6:4] == 3'b010 && bus_addr[1:0] == 2'b00) wd[bus_addr[3:2]] <= bus_wdata;
        if (bus_addr == 7'h0C) begin
          dev <= bus_wdata[9:8];
          rel <= bus_wdata[16];
          if (bus_wdata[0]) begin
            busy <= 1'b1; ph <= ld_ph; sh <= ld_val; cnt <= cyc[ld_ph];
            half <= 1'b0; rsh <= '0;
          end
        end
      end
    end else if (ph == PH_DONE) begin
      busy <= 1'b0;
      rd <= rnext;
    end else if (!half) begin
      half <= 1'b1;
      sck <= 1'b1;
      if (ph == 3'd4)
        case (ps_cur)
          2'd2: rsh <= {rsh[SW-5:0], io_in};
          2'd1: rsh <= {rsh[SW-3:0], io_in[1:0]};
          default: rsh <= {rsh[SW-2:0], io_in[1]};
        endcase
    end else begin
      half <= 1'b0;
      sck <= 1'b0;
      if (cnt == 8'd1) begin
        ph <= ld_ph; sh <= ld_val; cnt <= cyc[ld_ph];
      end else begin
        cnt <= cnt - 8'd1;
        sh <= sh << (1 << ps_cur);
      end
    end
  end

  wire drive = busy && (ph == 3'd0 || ph == 3'd1 || ph == 3'd3);
  assign io_oe = drive ? mask : 4'h0;
  assign io_out = io_oe & ((ps_cur == 2'd2) ? sh[SW-1 -: 4] :
                           (ps_cur == 2'd1) ? {2'b0, sh[SW-1 -: 2]} : {3'b0, sh[SW-1]});
  assign cs_n = ~((busy || !rel) ? (4'b0001 << dev) : 4'b0000);

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      7'h08: bus_rdata = cfg;
      7'h0C: bus_rdata = {15'b0, rel, 6'b0, dev, 7'b0, busy};
      7'h10: bus_rdata = cmd_r;
      7'h14: bus_rdata = adr_r;
      7'h20, 7'h24, 7'h28, 7'h2C: bus_rdata = wd[bus_addr[3:2]];
      7'h30, 7'h34, 7'h38, 7'h3C: bus_rdata = rd[bus_addr[3:2]];
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/flash_xact_engine_chk.sv
module flash_xact_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sck,
  input logic [3:0] cs_n,
  input logic [3:0] io_oe,
  input logic       busy,
  input logic [2:0] ph
);
  p_one_cs_r9: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~cs_n));
  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (!sck && io_oe == 4'h0));
  p_sck_half_r12: assert property (@(posedge clk) disable iff (!rst_n) (busy && sck) |=> !sck);
  p_cs_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n) busy |=> (!busy || $stable(cs_n)));
  p_dummy_hiz_r7: assert property (@(posedge clk) disable iff (!rst_n) (busy && ph == 3'd2) |-> io_oe == 4'h0);
  p_read_hiz_r8: assert property (@(posedge clk) disable iff (!rst_n) (busy && ph == 3'd4) |-> io_oe == 4'h0);
endmodule

bind flash_xact_engine flash_xact_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .io_oe(io_oe), .busy(busy), .ph(ph)
);

// File: tb/sim_flash_xact_engine.sv
module sim_flash_xact_engine;
  localparam int CLK_NS = 10;
  logic clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0;
  logic [6:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic sck;
  logic [3:0] cs_n, io_out, io_oe, io_in;
  int checks = 0, fails = 0;
  int rise_cnt = 0, base = 0, k0 = 0, rd_lanes = 1, rd_clocks = 0;
  logic [3:0] rec_out [512], rec_oe [512], rec_cs [512];
  logic [7:0] rd_src [16];
  logic [31:0] wdv [4];

  flash_xact_engine u0 (.clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck(sck), .cs_n(cs_n),
    .io_out(io_out), .io_oe(io_oe), .io_in(io_in));

  always #(CLK_NS/2) clk = ~clk;

  always @(posedge sck) begin
    int idx;
    idx = rise_cnt - base;
    if (idx >= 0 && idx < 512) begin
      rec_out[idx] <= io_out; rec_oe[idx] <= io_oe; rec_cs[idx] <= cs_n;
    end
    rise_cnt <= rise_cnt + 1;
  end

  always_comb begin
    int j;
    io_in = 4'h0;
    j = rise_cnt - base - k0;
    if (j >= 0 && j < rd_clocks)
      for (int l = 0; l < rd_lanes; l++) begin
        int p;
        p = j * rd_lanes + l;
        if (rd_lanes == 4) io_in[3-l] = rd_src[p/8][7-(p%8)];
        else if (rd_lanes == 2) io_in[1-l] = rd_src[p/8][7-(p%8)];
        else io_in[1] = rd_src[p/8][7-(p%8)];
      end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  function automatic int lanes(input logic [1:0] c);
    return (c == 2'd2) ? 4 : (c == 2'd1) ? 2 : 1;
  endfunction

  function automatic int minv(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  function automatic logic sbit(input int p, input int pos, input logic [31:0] cmdv,
                                input logic [31:0] adrv, input int an);
    int j;
    j = pos / 8;
    if (p == 0) return cmdv[7 - pos];
    if (p == 1) return adrv[8*(an-1-j) + 7 - pos%8];
    return wdv[j/4][8*(j%4) + 7 - pos%8];
  endfunction

  task automatic wait_idle();
    logic [31:0] v;
    int n = 0;
    do begin bus_read(7'h0C, v); n++; end while (v[0] && n < 3000);
    chk("R2", "start bit clears at end", {31'b0, v[0]}, 32'd0);
  endtask

  task automatic run_xact(input logic [31:0] cfgv, input logic [31:0] cmdv,
                          input logic [31:0] adrv, input logic [1:0] dv, input logic relv);
    int nb [5], ln [5], cl [5];
    int total, k, bad;
    logic [3:0] eo, ev;
    logic [31:0] v, e;
    nb[0] = cfgv[10] ? 1 : 0; ln[0] = lanes(cfgv[1:0]);
    nb[1] = minv(int'(cfgv[13:11]), 4); ln[1] = lanes(cfgv[3:2]);
    nb[2] = int'(cfgv[23:21]); ln[2] = lanes(cfgv[7:6]);
    nb[3] = minv(int'(cfgv[20:16]), 16); ln[3] = lanes(cfgv[5:4]);
    nb[4] = minv(int'(cfgv[28:24]), 16); ln[4] = lanes(cfgv[9:8]);
    total = 0;
    for (int p = 0; p < 5; p++) begin cl[p] = nb[p] * 8 / ln[p]; total += cl[p]; end
    bus_write(7'h08, cfgv); bus_write(7'h10, cmdv); bus_write(7'h14, adrv);
    for (int i = 0; i < 4; i++) bus_write(7'h20 + 7'(4*i), wdv[i]);
    for (int i = 0; i < 16; i++) rd_src[i] = 8'($urandom);
    k0 = cl[0] + cl[1] + cl[2] + cl[3]; rd_lanes = ln[4]; rd_clocks = cl[4];
    base = rise_cnt;
    bus_write(7'h0C, {15'b0, relv, 6'b0, dv, 8'h01});
    wait_idle();
    chk("R3 R4", "sck clock count", rise_cnt - base, total);
    k = 0;
    for (int p = 0; p < 5; p++) begin
      bad = 0;
      for (int c = 0; c < cl[p]; c++) begin
        eo = 4'h0; ev = 4'h0;
        if (p == 0 || p == 1 || p == 3) begin
          eo = (ln[p] == 4) ? 4'hF : (ln[p] == 2) ? 4'h3 : 4'h1;
          for (int l = 0; l < ln[p]; l++)
            ev[ln[p]-1-l] = sbit(p, c*ln[p] + l, cmdv, adrv, nb[1]);
        end
        if (k < 512 && (rec_oe[k] !== eo || (rec_out[k] & eo) !== ev)) bad++;
        if (k < 512 && rec_cs[k] !== ~(4'b0001 << dv)) bad++;
        k++;
      end
      case (p)
        0: chk("R3", "command phase lanes", bad, 0);
        1: chk("R5", "address phase lanes", bad, 0);
        2: chk("R7", "dummy phase tri-state", bad, 0);
        3: chk("R6", "write phase lanes", bad, 0);
        default: chk("R8 R9", "read phase oe and select", bad, 0);
      endcase
    end
    for (int w = 0; w < 4; w++) begin
      for (int b = 0; b < 4; b++) e[8*b +: 8] = (4*w + b < nb[4]) ? rd_src[4*w + b] : 8'h00;
      bus_read(7'h30 + 7'(4*w), v);
      chk("R8", "read word", v, e);
    end
  endtask

  initial begin
    logic [31:0] v, cfgv;
    void'($urandom(32'h5EED));
    for (int i = 0; i < 4; i++) wdv[i] = '0;
    for (int i = 0; i < 16; i++) rd_src[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    bus_read(7'h08, v); chk("R1", "config reset", v, 0);
    bus_read(7'h0C, v); chk("R1", "control reset", v, 32'h0001_0000);
    bus_read(7'h10, v); chk("R1", "command reset", v, 0);
    bus_read(7'h34, v); chk("R1", "read word reset", v, 0);
    chk("R1", "pins idle", {cs_n, io_oe, 3'b0, sck}, {4'hF, 4'h0, 4'h0});

    for (int i = 0; i < 4; i++) wdv[i] = $urandom;
    run_xact(32'h0, 32'h9F, 0, 2'd0, 1'b1);
    run_xact({3'b0, 5'd16, 3'd2, 5'd16, 2'b0, 3'd4, 1'b1, 2'd2, 2'd2, 2'd2, 2'd2, 2'd2},
             32'hEB, 32'h1234_5678, 2'd3, 1'b1);
    run_xact({3'b0, 5'd3, 3'd0, 5'd0, 2'b0, 3'd3, 1'b1, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0},
             32'h03, 32'hAB_CDEF12, 2'd1, 1'b1);
    run_xact({3'b0, 5'd31, 3'd1, 5'd0, 2'b0, 3'd7, 1'b0, 2'd1, 2'd0, 2'd0, 2'd1, 2'd0},
             32'h0, 32'hC0DE_F00D, 2'd2, 1'b1);

    for (int t = 0; t < 40; t++) begin
      for (int i = 0; i < 4; i++) wdv[i] = $urandom;
      cfgv = $urandom;
      run_xact(cfgv, $urandom, $urandom, 2'($urandom), 1'b1);
      chk("R10", "select released after transaction", {28'b0, cs_n}, 32'hF);
      chk("R12", "sck idles low", {31'b0, sck}, 0);
    end

    bus_write(7'h0C, 32'h0000_0200);
    chk("R10", "hold asserts select while idle", {28'b0, cs_n}, 32'hB);
    run_xact({21'b0, 1'b1, 10'b0}, 32'h06, 0, 2'd2, 1'b0);
    chk("R10", "hold keeps select after transaction", {28'b0, cs_n}, 32'hB);
    bus_write(7'h0C, 32'h0001_0200);
    chk("R10", "release deasserts select", {28'b0, cs_n}, 32'hF);

    bus_write(7'h08, {18'b0, 3'd4, 1'b1, 10'b0});
    bus_write(7'h10, 32'h11);
    base = rise_cnt; k0 = 999; rd_clocks = 0;
    bus_write(7'h0C, 32'h0001_0001);
    repeat (10) @(negedge clk);
    bus_write(7'h10, 32'h22);
    bus_write(7'h0C, 32'h0001_0301);
    wait_idle();
    chk("R11", "start while busy does not restart", rise_cnt - base, 40);
    chk("R11", "select unchanged while busy", {28'b0, rec_cs[39]}, 32'hE);
    bus_read(7'h10, v); chk("R11", "command write while busy ignored", v, 32'h11);

    bus_write(7'h08, {21'b0, 1'b1, 10'b0});
    bus_write(7'h0C, 32'h0001_0001);
    repeat (15) @(negedge clk);
    bus_write(7'h10, 32'hAA);
    bus_read(7'h0C, v); chk("R2", "finished after 8 clocks", {31'b0, v[0]}, 0);
    bus_read(7'h10, v); chk("R11", "write on finishing edge ignored", v, 32'h11);
    bus_write(7'h10, 32'hBB);
    bus_read(7'h10, v); chk("R11", "write after finish accepted", v, 32'hBB);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_NS * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired R2 actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule